// File: doc/BRIEF.md
# Chained Transmit Descriptor Sequencer

This block moves transmit data from system memory into a byte stream under the control of a chain of descriptors. Up to sixteen descriptors sit in a small local table that software fills through a simple word-wide access port. Each descriptor names a word-aligned buffer, a length in 32-bit words, a trim code for the last word, frame-boundary marks and chaining options. The sequencer waits until the descriptor at its current index has its start bit set. It then reads the buffer one word at a time over a request/response port and hands the bytes on, lowest byte first, with start-of-frame and end-of-frame marks attached.

When a descriptor ends, the sequencer writes its status back into the table: the start bit is cleared and any bus error is recorded as a one-hot code. It then pulses an interrupt unless that descriptor asks for silence. A descriptor flagged as having a successor moves the index on by one, and the successor runs as soon as its own start bit is set. A descriptor without that flag leaves the index where it is and ends the chain. A bus error always ends the chain and always interrupts.

Top module: `dma_chain_seq`

## Requirements
- R1: After synchronous reset the current index is 0, no read request and no output byte are presented, the interrupt is low and every table word reads as zero.
- R2: The sequencer starts a descriptor only when bit 31 (start) of the high word at the current index is 1. While that bit is 0 it issues no read request.
- R3: A descriptor of length N (high word bits 10:0, in words) produces N read requests at addresses base, base+4, and so on, in that order. The base is the low word with bits 1:0 cleared. At most one word is in flight at a time, and an unaccepted request holds its address.
- R4: The bytes of each returned word leave lowest byte (bits 7:0) first, one per accepted transfer. A byte that is not accepted stays on the output unchanged.
- R5: The low word bits 1:0 trim only the final word of a descriptor: 00 keeps 4 bytes, 01 keeps 1 byte, 10 keeps 2 bytes, 11 keeps 3 bytes. Kept bytes start from the lowest.
- R6: High word bit 30 marks the first byte of the descriptor as frame start. Bit 29 marks its last byte as frame end. No other byte carries a mark.
- R7: On normal completion the high word is rewritten with bit 31 cleared, bits 14:11 zero and every other bit unchanged. While the descriptor is in progress, bit 31 reads back as 1.
- R8: High word bit 24 set advances the index by one after completion, and the next descriptor runs once its start bit is set. Bit 24 clear leaves the index unchanged and ends the chain.
- R9: Each completed descriptor gives a one-cycle interrupt pulse, unless high word bit 27 is set.
- R10: A read response flagged as an error with kind k (0 master abort, 1 target abort, 2 disconnect timeout, 3 retry timeout) sets bit 11+k of the high word and clears bit 31. No bytes are sent from that word. The chain stops with the index unchanged, and the interrupt pulses whatever bit 27 says.
- R11: Advancing from index 15 wraps to index 0.
- R12: A descriptor of length 0 completes with write-back and interrupt but issues no read request and sends no byte.
- R13: The access port addresses a table word by sw_addr: bit 0 selects the high word (1) or low word (0), and the upper bits give the index. A write-back from the sequencer wins over a software write to the same word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Table write strobe |
| sw_addr | input | IDX_W+1 | Table word address: index in upper bits, bit 0 selects the high word |
| sw_wdata | input | 32 | Table write data |
| sw_rdata | output | 32 | Table read data at sw_addr |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_err | input | 1 | Read response carries a bus error |
| rd_rsp_err_kind | input | 2 | Bus error kind (0..3) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is frame start |
| out_eof | output | 1 | Output byte is frame end |
| irq | output | 1 | One-cycle completion interrupt |
| cur_idx | output | IDX_W | Current descriptor index |

## Verification
The stream is exercised with a single multi-word descriptor with full last word and both frame marks. A three-link chain mixes trims 11, 10 and 01, a suppressed interrupt and frame marks on different links, which separates per-descriptor trimming and marking from chain-level behaviour. A fifteen-link chain crossing index 15 tells the wrap apart from a stop. Error responses on a middle word and on the first word, with two different kinds, separate partial output and the error code position from the interrupt-suppress bit. A zero-length descriptor and an idle index with the start bit cleared show that no memory traffic is issued without need. Backpressure on both the request and the byte side is irregular throughout, so held data and one-word-in-flight ordering are tried under stalls.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 11;

    localparam int B_GO     = 31;
    localparam int B_SOF    = 30;
    localparam int B_EOF    = 29;
    localparam int B_NOIRQ  = 27;
    localparam int B_MORE   = 24;
    localparam int B_ERR_LO = 11;

    localparam logic [WORD_W-1:0] WB_CLEAR_MASK = 32'h8000_7800;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EMIT,
        ST_WB
    } seq_state_e;

    typedef struct packed {
        logic [29:0]      word_addr;
        logic [1:0]       align;
        logic [LEN_W-1:0] len;
        logic             sof;
        logic             eof;
        logic             noirq;
        logic             more;
    } desc_t;

    function automatic desc_t decode_desc(input logic [WORD_W-1:0] lo,
                                          input logic [WORD_W-1:0] hi);
        desc_t d;
        d.word_addr = lo[31:2];
        d.align     = lo[1:0];
        d.len       = hi[LEN_W-1:0];
        d.sof       = hi[B_SOF];
        d.eof       = hi[B_EOF];
        d.noirq     = hi[B_NOIRQ];
        d.more      = hi[B_MORE];
        return d;
    endfunction

    // valid bytes in the final word, from the trim code
    function automatic logic [2:0] tail_bytes(input logic [1:0] code);
        logic [2:0] n;
        case (code)
            2'b00:   n = 3'd4;
            2'b01:   n = 3'd1;
            2'b10:   n = 3'd2;
            default: n = 3'd3;
        endcase
        return n;
    endfunction

    function automatic logic [3:0] err_code(input logic [1:0] kind);
        return 4'b0001 << kind;
    endfunction

endpackage

// File: rtl/desc_table.sv
module desc_table #(
    parameter int NDESC = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic             sw_sel_hi,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic [IDX_W-1:0] sq_idx,
    output logic [31:0]      sq_lo,
    output logic [31:0]      sq_hi,
    input  logic             wb_we,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [31:0]      wb_hi
);

    logic [31:0] lo_mem [NDESC];
    logic [31:0] hi_mem [NDESC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NDESC; i++) begin
                lo_mem[i] <= '0;
                hi_mem[i] <= '0;
            end
        end else begin
            if (sw_we) begin
                if (sw_sel_hi) hi_mem[sw_idx] <= sw_wdata;
                else           lo_mem[sw_idx] <= sw_wdata;
            end
            // sequencer write-back is last, so it wins a same-word clash
            if (wb_we) hi_mem[wb_idx] <= wb_hi;
        end
    end

    assign sw_rdata = sw_sel_hi ? hi_mem[sw_idx] : lo_mem[sw_idx];
    assign sq_lo    = lo_mem[sq_idx];
    assign sq_hi    = hi_mem[sq_idx];

endmodule

// File: rtl/word_unpack.sv
module word_unpack (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] load_word,
    input  logic [2:0]  load_nbytes,
    input  logic        load_sof,
    input  logic        load_eof,
    output logic        busy,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof
);

    logic [31:0] word_q;
    logic [2:0]  nb_q;
    logic        sof_q;
    logic        eof_q;
    logic [1:0]  pos_q;
    logic        busy_q;
    logic        at_last;

    assign at_last   = ({1'b0, pos_q} == (nb_q - 3'd1));
    assign busy      = busy_q;
    assign out_valid = busy_q;
    assign out_data  = 8'(word_q >> {pos_q, 3'b000});
    assign out_sof   = busy_q && sof_q && (pos_q == 2'd0);
    assign out_eof   = busy_q && eof_q && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            nb_q   <= '0;
            sof_q  <= 1'b0;
            eof_q  <= 1'b0;
            pos_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            word_q <= load_word;
            nb_q   <= load_nbytes;
            sof_q  <= load_sof;
            eof_q  <= load_eof;
            pos_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && out_ready) begin
            if (at_last) busy_q <= 1'b0;
            else         pos_q  <= pos_q + 2'd1;
        end
    end

endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
    import dchain_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      d_lo,
    input  logic [31:0]      d_hi,
    output logic [IDX_W-1:0] cur_idx,
    output logic             wb_we,
    output logic [31:0]      wb_hi,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [31:0]      rd_req_addr,
    input  logic             rd_rsp_valid,
    input  logic [31:0]      rd_rsp_data,
    input  logic             rd_rsp_err,
    input  logic [1:0]       rd_rsp_err_kind,
    output logic             unp_load,
    output logic [31:0]      unp_word,
    output logic [2:0]       unp_nbytes,
    output logic             unp_sof,
    output logic             unp_eof,
    input  logic             unp_busy,
    output logic             irq
);

    seq_state_e       state_q;
    logic [31:0]      lo_q;
    logic [31:0]      hi_q;
    logic [LEN_W-1:0] wcnt_q;
    logic [3:0]       err_q;
    logic [IDX_W-1:0] idx_q;
    logic             irq_q;
    desc_t            cur;
    desc_t            nxt;
    logic             last_word;

    assign cur       = decode_desc(lo_q, hi_q);
    assign nxt       = decode_desc(d_lo, d_hi);
    assign last_word = (wcnt_q == cur.len - LEN_W'(1));

    assign cur_idx      = idx_q;
    assign irq          = irq_q;
    assign rd_req_valid = (state_q == ST_REQ);
    assign rd_req_addr  = {cur.word_addr + 30'(wcnt_q), 2'b00};

    assign unp_load   = (state_q == ST_WAIT) && rd_rsp_valid && !rd_rsp_err;
    assign unp_word   = rd_rsp_data;
    assign unp_nbytes = last_word ? tail_bytes(cur.align) : 3'd4;
    assign unp_sof    = cur.sof && (wcnt_q == '0);
    assign unp_eof    = cur.eof && last_word;

    assign wb_we = (state_q == ST_WB);
    assign wb_hi = (hi_q & ~WB_CLEAR_MASK) | (32'(err_q) << B_ERR_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
            hi_q    <= '0;
            wcnt_q  <= '0;
            err_q   <= '0;
            idx_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (d_hi[B_GO]) begin
                        lo_q    <= d_lo;
                        hi_q    <= d_hi;
                        wcnt_q  <= '0;
                        err_q   <= '0;
                        state_q <= (nxt.len == '0) ? ST_WB : ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (rd_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (rd_rsp_err) begin
                            err_q   <= err_code(rd_rsp_err_kind);
                            state_q <= ST_WB;
                        end else begin
                            state_q <= ST_EMIT;
                        end
                    end
                end
                ST_EMIT: begin
                    if (!unp_busy) begin
                        if (last_word) begin
                            state_q <= ST_WB;
                        end else begin
                            wcnt_q  <= wcnt_q + LEN_W'(1);
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_WB: begin
                    irq_q <= (err_q != '0) || !cur.noirq;
                    if (err_q == '0 && cur.more) idx_q <= idx_q + IDX_W'(1);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
    parameter  int NDESC = 16,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [IDX_W:0]   sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [31:0]      rd_req_addr,
    input  logic             rd_rsp_valid,
    input  logic [31:0]      rd_rsp_data,
    input  logic             rd_rsp_err,
    input  logic [1:0]       rd_rsp_err_kind,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             irq,
    output logic [IDX_W-1:0] cur_idx
);

    logic [31:0]      d_lo;
    logic [31:0]      d_hi;
    logic             wb_we;
    logic [31:0]      wb_hi;
    logic             unp_load;
    logic [31:0]      unp_word;
    logic [2:0]       unp_nbytes;
    logic             unp_sof;
    logic             unp_eof;
    logic             unp_busy;

    desc_table #(.NDESC(NDESC), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .sw_we     (sw_we),
        .sw_sel_hi (sw_addr[0]),
        .sw_idx    (sw_addr[IDX_W:1]),
        .sw_wdata  (sw_wdata),
        .sw_rdata  (sw_rdata),
        .sq_idx    (cur_idx),
        .sq_lo     (d_lo),
        .sq_hi     (d_hi),
        .wb_we     (wb_we),
        .wb_idx    (cur_idx),
        .wb_hi     (wb_hi)
    );

    chain_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .d_lo            (d_lo),
        .d_hi            (d_hi),
        .cur_idx         (cur_idx),
        .wb_we           (wb_we),
        .wb_hi           (wb_hi),
        .rd_req_valid    (rd_req_valid),
        .rd_req_ready    (rd_req_ready),
        .rd_req_addr     (rd_req_addr),
        .rd_rsp_valid    (rd_rsp_valid),
        .rd_rsp_data     (rd_rsp_data),
        .rd_rsp_err      (rd_rsp_err),
        .rd_rsp_err_kind (rd_rsp_err_kind),
        .unp_load        (unp_load),
        .unp_word        (unp_word),
        .unp_nbytes      (unp_nbytes),
        .unp_sof         (unp_sof),
        .unp_eof         (unp_eof),
        .unp_busy        (unp_busy),
        .irq             (irq)
    );

    word_unpack u_unpack (
        .clk         (clk),
        .rst         (rst),
        .load        (unp_load),
        .load_word   (unp_word),
        .load_nbytes (unp_nbytes),
        .load_sof    (unp_sof),
        .load_eof    (unp_eof),
        .busy        (unp_busy),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sof     (out_sof),
        .out_eof     (out_eof)
    );

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [31:0]      rd_req_addr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_sof,
    input logic             out_eof,
    input logic             irq,
    input logic [IDX_W-1:0] cur_idx
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R3
    one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !rd_req_valid);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sof) && $stable(out_eof));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R11
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_idx) |-> cur_idx == IDX_W'($past(cur_idx) + 1'b1));

    // R8
    idx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> $stable(cur_idx));

endmodule

bind dma_chain_seq dma_chain_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_sof      (out_sof),
    .out_eof      (out_eof),
    .irq          (irq),
    .cur_idx      (cur_idx)
);

// File: tb/tb_dma_chain_seq.sv
module tb_dma_chain_seq;

    localparam int NDESC = 16;
    localparam int IDX_W = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst = 1'b1;
    logic             sw_we = 1'b0;
    logic [IDX_W:0]   sw_addr = '0;
    logic [31:0]      sw_wdata = '0;
    logic [31:0]      sw_rdata;
    logic             rd_req_valid;
    logic             rd_req_ready = 1'b0;
    logic [31:0]      rd_req_addr;
    logic             rd_rsp_valid = 1'b0;
    logic [31:0]      rd_rsp_data = '0;
    logic             rd_rsp_err = 1'b0;
    logic [1:0]       rd_rsp_err_kind = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;
    logic             out_sof;
    logic             out_eof;
    logic             irq;
    logic [IDX_W-1:0] cur_idx;

    dma_chain_seq #(.NDESC(NDESC)) dut (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .rd_rsp_err_kind(rd_rsp_err_kind), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .irq(irq), .cur_idx(cur_idx)
    );

    typedef struct packed {
        logic       sof;
        logic       eof;
        logic [7:0] d;
    } ob_t;

    ob_t exp_q[$];
    int  checks = 0;
    int  errors = 0;
    int  irq_cnt = 0;
    int  req_cnt = 0;
    int  cyc = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [1:0]  err_kind = 2'd0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5AC3, a[15:0] + 16'h1111};
    endfunction

    function automatic int exp_tail(input logic [1:0] code);
        if (code == 2'b00) return 4;
        return int'(code);
    endfunction

    function automatic logic [31:0] mk_hi(input int len, input bit sof, input bit eof,
                                          input bit noirq, input bit more, input bit go);
        return (32'(go) << 31) | (32'(sof) << 30) | (32'(eof) << 29) |
               (32'(noirq) << 27) | (32'(more) << 24) | 32'(len);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // stimulus pattern for handshakes and the memory model
    always @(posedge clk) begin
        cyc          <= cyc + 1;
        out_ready    <= (cyc % 3) != 2;
        rd_req_ready <= (cyc % 4) != 1;
        rd_rsp_valid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else if (pend) begin
            rd_rsp_valid    <= 1'b1;
            rd_rsp_data     <= mem_word(pend_addr);
            rd_rsp_err      <= (pend_addr == err_addr);
            rd_rsp_err_kind <= err_kind;
            pend            <= 1'b0;
        end else if (rd_req_valid && rd_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= rd_req_addr;
            req_cnt   <= req_cnt + 1;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_cnt++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected byte", {24'd0, out_data}, 32'd0);
                end else begin
                    ob_t e;
                    e = exp_q.pop_front();
                    chk({out_sof, out_eof, out_data} == e, "R4/R5/R6 byte {sof,eof,data}",
                        {22'd0, out_sof, out_eof, out_data}, {22'd0, e});
                end
            end
        end
    end

    task automatic expect_desc(input logic [31:0] base, input int len, input logic [1:0] align,
                               input bit sof, input bit eof, input int err_word);
        for (int k = 0; k < len; k++) begin
            logic [31:0] w;
            int nb;
            if (k == err_word) break;
            nb = (k == len - 1) ? exp_tail(align) : 4;
            w  = mem_word(base + 32'(4 * k));
            for (int b = 0; b < nb; b++) begin
                ob_t e;
                e.d   = w[8*b +: 8];
                e.sof = sof && (k == 0) && (b == 0);
                e.eof = eof && (k == len - 1) && (b == nb - 1);
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic wr(input int idx, input bit hi, input logic [31:0] v);
        @(negedge clk);
        sw_we    = 1'b1;
        sw_addr  = {4'(idx), hi};
        sw_wdata = v;
        @(negedge clk);
        sw_we    = 1'b0;
    endtask

    task automatic rd_hi(input int idx, output logic [31:0] v);
        @(negedge clk);
        sw_addr = {4'(idx), 1'b1};
        #1 v = sw_rdata;
    endtask

    task automatic wait_go_clear(input int idx);
        logic [31:0] v;
        do rd_hi(idx, v); while (v[31]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    bit finished = 1'b0;
    always @(posedge clk) begin
        if (!finished && cyc > 150000) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] h;
        int irq0;
        int req0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cur_idx == 0, "R1 index after reset", 32'(cur_idx), 0);
        chk(!irq && !out_valid && !rd_req_valid, "R1 outputs idle after reset",
            {29'd0, irq, out_valid, rd_req_valid}, 0);
        rd_hi(5, v);
        chk(v == 0, "R1 table cleared", v, 0);
        // R2 nothing happens while start bit is clear
        idle(20);
        chk(req_cnt == 0, "R2 no request without start", 32'(req_cnt), 0);

        // Test 1: single descriptor, full last word, both marks
        h = mk_hi(3, 1, 1, 0, 0, 1);
        expect_desc(32'h1000, 3, 2'b00, 1, 1, -1);
        irq0 = irq_cnt;
        wr(0, 0, 32'h1000);
        wr(0, 1, h);
        idle(3);
        rd_hi(0, v);
        chk(v[31] == 1'b1, "R7 start bit reads 1 while active", v, h);
        wait_go_clear(0);
        idle(4);
        rd_hi(0, v);
        chk(v == (h & 32'h7FFF_FFFF), "R7 write-back word", v, h & 32'h7FFF_FFFF);
        chk(irq_cnt == irq0 + 1, "R9 one interrupt", 32'(irq_cnt - irq0), 1);
        chk(cur_idx == 0, "R8 last descriptor keeps index", 32'(cur_idx), 0);
        chk(exp_q.size() == 0, "R3 all bytes delivered", 32'(exp_q.size()), 0);
        req0 = req_cnt;
        idle(20);
        chk(req_cnt == req0, "R2 idle after finished chain", 32'(req_cnt - req0), 0);

        // Test 2: three-link chain with trims 11, 10, 01
        irq0 = irq_cnt;
        expect_desc(32'h1040, 1, 2'b11, 1, 0, -1);
        expect_desc(32'h1100, 2, 2'b10, 0, 1, -1);
        expect_desc(32'h1200, 1, 2'b01, 1, 1, -1);
        wr(1, 0, 32'h1102);
        wr(1, 1, mk_hi(2, 0, 1, 0, 1, 1));
        wr(2, 0, 32'h1201);
        wr(2, 1, mk_hi(1, 1, 1, 0, 0, 1));
        wr(0, 0, 32'h1043);
        wr(0, 1, mk_hi(1, 1, 0, 1, 1, 1));
        wait_go_clear(2);
        idle(4);
        chk(exp_q.size() == 0, "R5 chain bytes delivered", 32'(exp_q.size()), 0);
        chk(irq_cnt == irq0 + 2, "R9 suppressed interrupt on link 0",
            32'(irq_cnt - irq0), 2);
        chk(cur_idx == 2, "R8 chain advanced to index 2", 32'(cur_idx), 2);

        // Test 3: long chain crossing index 15
        irq0 = irq_cnt;
        expect_desc(32'h2F00, 1, 2'b00, 0, 0, -1);
        for (int i = 3; i < 16; i++) begin
            expect_desc(32'h3000 + 32'(i * 16), 1, 2'b00, 0, 0, -1);
            wr(i, 0, 32'h3000 + 32'(i * 16));
            wr(i, 1, mk_hi(1, 0, 0, 1, 1, 1));
        end
        expect_desc(32'h3F00, 2, 2'b11, 0, 1, -1);
        wr(0, 0, 32'h3F03);
        wr(0, 1, mk_hi(2, 0, 1, 0, 0, 1));
        wr(2, 0, 32'h2F00);
        wr(2, 1, mk_hi(1, 0, 0, 1, 1, 1));
        wait_go_clear(0);
        idle(4);
        chk(cur_idx == 0, "R11 index wrapped to 0", 32'(cur_idx), 0);
        chk(irq_cnt == irq0 + 1, "R9 only final link interrupts", 32'(irq_cnt - irq0), 1);
        chk(exp_q.size() == 0, "R11 wrap bytes delivered", 32'(exp_q.size()), 0);

        // Test 4: disconnect timeout on word 1, interrupt suppressed, more set
        irq0 = irq_cnt;
        req0 = req_cnt;
        wr(1, 0, 32'h5000);
        wr(1, 1, mk_hi(1, 0, 0, 0, 0, 1));
        err_addr = 32'h4004;
        err_kind = 2'd2;
        h = mk_hi(3, 1, 1, 1, 1, 1);
        expect_desc(32'h4000, 3, 2'b00, 1, 1, 1);
        wr(0, 0, 32'h4000);
        wr(0, 1, h);
        wait_go_clear(0);
        idle(30);
        rd_hi(0, v);
        chk(v == ((h & 32'h7FFF_FFFF) | 32'h2000), "R10 disconnect timeout code",
            v, (h & 32'h7FFF_FFFF) | 32'h2000);
        chk(irq_cnt == irq0 + 1, "R10 interrupt despite suppress", 32'(irq_cnt - irq0), 1);
        chk(cur_idx == 0, "R10 index unchanged on error", 32'(cur_idx), 0);
        chk(req_cnt == req0 + 2, "R10 chain stopped after error", 32'(req_cnt - req0), 2);
        chk(exp_q.size() == 0, "R10 bytes before error only", 32'(exp_q.size()), 0);
        rd_hi(1, v);
        chk(v[31] == 1'b1, "R10 next link untouched", v, 32'h8000_0001);

        // Test 5: retry timeout on the first word, no bytes
        irq0 = irq_cnt;
        err_addr = 32'h6000;
        err_kind = 2'd3;
        h = mk_hi(2, 1, 0, 0, 0, 1);
        wr(0, 0, 32'h6000);
        wr(0, 1, h);
        wait_go_clear(0);
        idle(4);
        rd_hi(0, v);
        chk(v == ((h & 32'h7FFF_FFFF) | 32'h4000), "R10 retry timeout code",
            v, (h & 32'h7FFF_FFFF) | 32'h4000);
        chk(irq_cnt == irq0 + 1, "R10 retry error interrupt", 32'(irq_cnt - irq0), 1);
        err_addr = 32'hFFFF_FFFF;

        // Test 6: zero-length descriptor
        irq0 = irq_cnt;
        req0 = req_cnt;
        h = mk_hi(0, 1, 1, 0, 0, 1);
        wr(0, 1, h);
        wait_go_clear(0);
        idle(4);
        rd_hi(0, v);
        chk(v == (h & 32'h7FFF_FFFF), "R12 zero length write-back", v, h & 32'h7FFF_FFFF);
        chk(req_cnt == req0, "R12 no request for zero length", 32'(req_cnt - req0), 0);
        chk(irq_cnt == irq0 + 1, "R12 zero length interrupt", 32'(irq_cnt - irq0), 1);

        // R13 software write to the low word reads back
        wr(7, 0, 32'hCAFE_0004);
        @(negedge clk);
        sw_addr = {4'd7, 1'b0};
        #1 chk(sw_rdata == 32'hCAFE_0004, "R13 table access", sw_rdata, 32'hCAFE_0004);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule